// File: doc/BRIEF.md
# Entropy Seed Register Access Gate

This block decides whether a CSR instruction that names the 32-bit entropy seed register may read it. Each request carries the CSR operation, the source field of the instruction, the current privilege mode and the machine security configuration word. The gate looks at two grant bits in that word and at the instruction form. It then returns one of three verdicts: granted, illegal-instruction trap or virtual-instruction trap.

A granted access returns the seed word that the entropy source presents in the request cycle. In the same cycle it sends a single pop pulse, so that the source can move on to fresh entropy. A refused access returns zero data and leaves the entropy source untouched. Every request is answered one clock cycle after it is presented. A new request may be presented on every cycle.

Top module: `seed_access_gate`

## Requirements
- R1: After reset, `rspValid`, `rspOk`, `rspIllegal`, `rspVirtual` and `seedPop` are 0 and `rspData` is zero.
- R2: A request presented with `reqValid`=1 at a rising edge is answered at the next rising edge by a one-cycle `rspValid`. `rspValid` is never high in a cycle that does not follow a request, and back-to-back requests get back-to-back responses.
- R3: An access is read-only when `reqOp` is set (2'b10) or clear (2'b11) and `reqSrc` is zero. This covers both the register and the immediate form, because `reqSrc` holds the register index or the immediate. A read-only access always gets the illegal-instruction verdict, whatever the mode and the grant bits.
- R4: A read-write access is write (2'b01) with any `reqSrc`, or set/clear with a non-zero `reqSrc`. In machine mode (`reqMode`=3'b011) a read-write access is always granted, and `rspData` equals the `seedWord` sampled in the request cycle.
- R5: In user mode (3'b000), a read-write access is granted when the user grant bit (bit 8 of `secCfg`) is 1. Otherwise it is illegal.
- R6: In supervisor mode (3'b001, which also covers the hypervisor-supervisor level), a read-write access is granted when the supervisor grant bit (bit 9 of `secCfg`) is 1. Otherwise it is illegal.
- R7: In virtual supervisor (3'b101) and virtual user (3'b100) modes the access is never granted. With bit 9 at 0 it is illegal. With bit 9 at 1 a read-write access gets the virtual-instruction verdict. Bit 8 never changes the verdict in these modes.
- R8: `seedPop` pulses for exactly one cycle, together with each granted response, and never with a refused one. `rspData` is zero on every refused response.
- R9: The write value `reqWdata` has no effect on the verdict, the data or the pop.
- R10: Operation code 2'b00 and the mode codes 3'b010, 3'b110 and 3'b111 are reserved and always get the illegal-instruction verdict.
- R11: While `rspValid` is 1, exactly one of `rspOk`, `rspIllegal` and `rspVirtual` is 1. While `rspValid` is 0, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, one request per cycle |
| reqOp | input | 2 | CSR operation: 01 write, 10 set, 11 clear, 00 reserved |
| reqSrc | input | 5 | Source register index or immediate of the instruction |
| reqWdata | input | 32 | Write value of the instruction (ignored) |
| reqMode | input | 3 | Privilege mode {virtual, level[1:0]} |
| secCfg | input | 64 | Machine security configuration word |
| seedWord | input | 32 | Current word from the entropy source |
| rspValid | output | 1 | Response strobe |
| rspOk | output | 1 | Access granted |
| rspIllegal | output | 1 | Illegal-instruction trap |
| rspVirtual | output | 1 | Virtual-instruction trap |
| rspData | output | 32 | Seed word on grant, zero otherwise |
| seedPop | output | 1 | One-cycle consume pulse to the entropy source |

## Verification
The bench targets the read-only forms in every mode with both grant bits set. A gate that checks the mode before the form would grant those reads or give them the virtual verdict. In virtual modes it sweeps all four settings of the grant bits. A design that looks at the user bit in virtual user mode would return illegal where virtual is expected. It also covers set and clear with a non-zero source, which a sloppy decoder treats as read-only, and refusals, where a stray pop or leaked seed data would show at the ports. Back-to-back requests with changing seed words catch a design that samples the seed word one cycle late.

// File: rtl/seed_gate_pkg.sv
package seed_gate_pkg;

  typedef enum logic [1:0] {
    OP_RSVD  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csrOpE;

  typedef enum logic [2:0] {
    MODE_U  = 3'b000,
    MODE_S  = 3'b001,
    MODE_M  = 3'b011,
    MODE_VU = 3'b100,
    MODE_VS = 3'b101
  } privModeE;

  // Strobes from control to datapath, valid in the request cycle.
  typedef struct packed {
    logic load;
    logic grant;
    logic trapIll;
    logic trapVirt;
  } gateStrobeT;

endpackage

// File: rtl/seed_gate_classify.sv
module seed_gate_classify
  import seed_gate_pkg::*;
#(
  parameter int SRC_W = 5
) (
  input  logic [1:0]       reqOp,
  input  logic [SRC_W-1:0] reqSrc,
  input  logic [2:0]       reqMode,
  output logic             opKnown,
  output logic             readOnly,
  output logic             modeKnown,
  output logic             modeMachine,
  output logic             modeUser,
  output logic             modeSuper,
  output logic             modeVirt
);

  logic srcZero;
  assign srcZero = (reqSrc == '0);

  always_comb begin
    opKnown  = 1'b1;
    readOnly = 1'b0;
    case (reqOp)
      OP_WRITE: readOnly = 1'b0;
      OP_SET,
      OP_CLEAR: readOnly = srcZero;
      default:  opKnown  = 1'b0;
    endcase
  end

  always_comb begin
    modeKnown   = 1'b1;
    modeMachine = 1'b0;
    modeUser    = 1'b0;
    modeSuper   = 1'b0;
    modeVirt    = 1'b0;
    case (reqMode)
      MODE_M:  modeMachine = 1'b1;
      MODE_S:  modeSuper   = 1'b1;
      MODE_U:  modeUser    = 1'b1;
      MODE_VS,
      MODE_VU: modeVirt    = 1'b1;
      default: modeKnown   = 1'b0;
    endcase
  end

endmodule

// File: rtl/seed_gate_ctrl.sv
module seed_gate_ctrl
  import seed_gate_pkg::*;
#(
  parameter int CFG_W     = 64,
  parameter int SSEED_BIT = 9,
  parameter int USEED_BIT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CFG_W-1:0] secCfg,
  input  logic             opKnown,
  input  logic             readOnly,
  input  logic             modeKnown,
  input  logic             modeMachine,
  input  logic             modeUser,
  input  logic             modeSuper,
  input  logic             modeVirt,
  output gateStrobeT       strb
);

  logic superGrant;
  logic userGrant;
  logic formRefused;

  assign superGrant  = secCfg[SSEED_BIT];
  assign userGrant   = secCfg[USEED_BIT];
  assign formRefused = !opKnown || !modeKnown || readOnly;

  always_comb begin
    strb      = '0;
    strb.load = reqValid;
    if (reqValid) begin
      if (formRefused) begin
        strb.trapIll = 1'b1;
      end else if (modeMachine) begin
        strb.grant = 1'b1;
      end else if (modeSuper) begin
        strb.grant   = superGrant;
        strb.trapIll = !superGrant;
      end else if (modeUser) begin
        strb.grant   = userGrant;
        strb.trapIll = !userGrant;
      end else if (modeVirt) begin
        strb.trapVirt = superGrant;
        strb.trapIll  = !superGrant;
      end else begin
        strb.trapIll = 1'b1;
      end
    end
  end

  // R3
  ro_always_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && readOnly) |-> (strb.trapIll && !strb.grant && !strb.trapVirt));

  // R4
  machine_rw_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && modeMachine && opKnown && !readOnly) |-> strb.grant);

  // R7
  virt_never_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && modeVirt) |-> !strb.grant);

endmodule

// File: rtl/seed_gate_dp.sv
module seed_gate_dp
  import seed_gate_pkg::*;
#(
  parameter int SEED_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobeT        strb,
  input  logic [SEED_W-1:0] seedWord,
  output logic              rspValid,
  output logic              rspOk,
  output logic              rspIllegal,
  output logic              rspVirtual,
  output logic [SEED_W-1:0] rspData,
  output logic              seedPop
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspOk      <= 1'b0;
      rspIllegal <= 1'b0;
      rspVirtual <= 1'b0;
      seedPop    <= 1'b0;
      rspData    <= '0;
    end else begin
      rspValid   <= strb.load;
      rspOk      <= strb.grant;
      rspIllegal <= strb.trapIll;
      rspVirtual <= strb.trapVirt;
      seedPop    <= strb.grant;
      rspData    <= strb.grant ? seedWord : '0;
    end
  end

  // R11
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($countones({rspOk, rspIllegal, rspVirtual}) == 1));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspOk || rspIllegal || rspVirtual));

  // R8
  pop_with_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedPop |-> (rspValid && rspOk));

  // R8
  refused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspOk) |-> (rspData == '0 && !seedPop));

  // R8
  pop_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seedPop && !strb.grant) |=> !seedPop);

endmodule

// File: rtl/seed_access_gate.sv
module seed_access_gate
  import seed_gate_pkg::*;
#(
  parameter int CFG_W     = 64,
  parameter int SEED_W    = 32,
  parameter int SRC_W     = 5,
  parameter int SSEED_BIT = 9,
  parameter int USEED_BIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [SEED_W-1:0] reqWdata,
  input  logic [2:0]        reqMode,
  input  logic [CFG_W-1:0]  secCfg,
  input  logic [SEED_W-1:0] seedWord,
  output logic              rspValid,
  output logic              rspOk,
  output logic              rspIllegal,
  output logic              rspVirtual,
  output logic [SEED_W-1:0] rspData,
  output logic              seedPop
);

  // The write value of the instruction never reaches the seed register.
  logic unusedWdata;
  assign unusedWdata = ^reqWdata;

  logic opKnown, readOnly, modeKnown;
  logic modeMachine, modeUser, modeSuper, modeVirt;
  gateStrobeT strb;

  seed_gate_classify #(.SRC_W(SRC_W)) u_classify (
    .reqOp       (reqOp),
    .reqSrc      (reqSrc),
    .reqMode     (reqMode),
    .opKnown     (opKnown),
    .readOnly    (readOnly),
    .modeKnown   (modeKnown),
    .modeMachine (modeMachine),
    .modeUser    (modeUser),
    .modeSuper   (modeSuper),
    .modeVirt    (modeVirt)
  );

  seed_gate_ctrl #(
    .CFG_W     (CFG_W),
    .SSEED_BIT (SSEED_BIT),
    .USEED_BIT (USEED_BIT)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .secCfg      (secCfg),
    .opKnown     (opKnown),
    .readOnly    (readOnly),
    .modeKnown   (modeKnown),
    .modeMachine (modeMachine),
    .modeUser    (modeUser),
    .modeSuper   (modeSuper),
    .modeVirt    (modeVirt),
    .strb        (strb)
  );

  seed_gate_dp #(.SEED_W(SEED_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .seedWord   (seedWord),
    .rspValid   (rspValid),
    .rspOk      (rspOk),
    .rspIllegal (rspIllegal),
    .rspVirtual (rspVirtual),
    .rspData    (rspData),
    .seedPop    (seedPop)
  );

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid));

endmodule

// File: tb/sim_seed_access_gate.sv
`timescale 1ns/1ps
module sim_seed_access_gate;

  localparam logic [2:0] M_U = 3'b000, M_S = 3'b001, M_M = 3'b011,
                         M_VU = 3'b100, M_VS = 3'b101;
  localparam logic [1:0] O_RSVD = 2'b00, O_WR = 2'b01, O_SET = 2'b10, O_CLR = 2'b11;
  localparam int K_OK = 0, K_ILL = 1, K_VIRT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'b00;
  logic [4:0]  reqSrc = '0;
  logic [31:0] reqWdata = '0;
  logic [2:0]  reqMode = 3'b000;
  logic [63:0] secCfg = '0;
  logic [31:0] seedWord = '0;
  logic        rspValid, rspOk, rspIllegal, rspVirtual, seedPop;
  logic [31:0] rspData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seed_access_gate u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqSrc(reqSrc),
    .reqWdata(reqWdata), .reqMode(reqMode), .secCfg(secCfg), .seedWord(seedWord),
    .rspValid(rspValid), .rspOk(rspOk), .rspIllegal(rspIllegal),
    .rspVirtual(rspVirtual), .rspData(rspData), .seedPop(seedPop)
  );

  function automatic logic [63:0] cfgOf(bit sBit, bit uBit);
    logic [63:0] c = 64'hFFFF_FFFF_FFFF_FCFF;
    c[9] = sBit;
    c[8] = uBit;
    return c;
  endfunction

  // Expected verdict taken from R3..R7 and R10.
  function automatic int expKind(logic [1:0] op, logic [4:0] src, logic [2:0] mode, logic [63:0] cfg);
    bit ro = (op == O_SET || op == O_CLR) && (src == 5'd0);
    if (op == O_RSVD || ro) return K_ILL;
    case (mode)
      M_M:        return K_OK;
      M_S:        return cfg[9] ? K_OK : K_ILL;
      M_U:        return cfg[8] ? K_OK : K_ILL;
      M_VS, M_VU: return cfg[9] ? K_VIRT : K_ILL;
      default:    return K_ILL;
    endcase
  endfunction

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one request at a falling edge, check the response one cycle later.
  task automatic issue(string tag, logic [1:0] op, logic [4:0] src, logic [2:0] mode,
                       logic [63:0] cfg, logic [31:0] wd, logic [31:0] seed);
    int k = expKind(op, src, mode, cfg);
    reqValid = 1'b1; reqOp = op; reqSrc = src; reqMode = mode;
    secCfg = cfg; reqWdata = wd; seedWord = seed;
    @(negedge clk);
    reqValid = 1'b0;
    seedWord = ~seed;
    checkVal({tag, " valid"}, {31'd0, rspValid}, 32'd1);
    checkVal({tag, " verdict"}, {29'd0, rspVirtual, rspIllegal, rspOk},
             (k == K_OK) ? 32'd1 : (k == K_ILL) ? 32'd2 : 32'd4);
    checkVal({tag, " data"}, rspData, (k == K_OK) ? seed : 32'd0);
    checkVal({tag, " pop"}, {31'd0, seedPop}, (k == K_OK) ? 32'd1 : 32'd0);
  endtask

  task automatic checkIdle(string tag);
    @(negedge clk);
    checkVal({tag, " idle"}, {26'd0, rspValid, rspOk, rspIllegal, rspVirtual, seedPop, |rspData}, 32'd0);
  endtask

  task automatic testReset();
    checkVal("R1 reset outputs",
             {26'd0, rspValid, rspOk, rspIllegal, rspVirtual, seedPop, |rspData}, 32'd0);
  endtask

  task automatic testReadOnly();
    logic [2:0] modes [5] = '{M_M, M_S, M_U, M_VS, M_VU};
    for (int m = 0; m < 5; m++)
      for (int c = 0; c < 4; c++) begin
        issue("R3 ro set", O_SET, 5'd0, modes[m], cfgOf(c[1], c[0]), 32'h1234, 32'hA5A5_0000 + c);
        issue("R3 ro clear", O_CLR, 5'd0, modes[m], cfgOf(c[1], c[0]), 32'hFFFF, 32'h5A5A_0000 + c);
      end
    checkIdle("R3");
  endtask

  task automatic testMachine();
    issue("R4 m write", O_WR, 5'd0, M_M, cfgOf(0, 0), 32'h0, 32'hDEAD_BEEF);
    issue("R4 m set nz", O_SET, 5'd7, M_M, cfgOf(0, 0), 32'h0, 32'h0BAD_F00D);
    issue("R4 m clear nz", O_CLR, 5'd31, M_M, cfgOf(0, 0), 32'h0, 32'h1357_9BDF);
    checkIdle("R4");
  endtask

  task automatic testUser();
    issue("R5 u off", O_WR, 5'd3, M_U, cfgOf(1, 0), 32'h0, 32'h1111_2222);
    issue("R5 u on", O_WR, 5'd3, M_U, cfgOf(0, 1), 32'h0, 32'h3333_4444);
    issue("R5 u on set", O_SET, 5'd1, M_U, cfgOf(0, 1), 32'h0, 32'h5555_6666);
    checkIdle("R5");
  endtask

  task automatic testSuper();
    issue("R6 s off", O_WR, 5'd2, M_S, cfgOf(0, 1), 32'h0, 32'h7777_8888);
    issue("R6 s on", O_CLR, 5'd2, M_S, cfgOf(1, 0), 32'h0, 32'h9999_AAAA);
    checkIdle("R6");
  endtask

  task automatic testVirtual();
    for (int c = 0; c < 4; c++) begin
      issue("R7 vs rw", O_WR, 5'd4, M_VS, cfgOf(c[1], c[0]), 32'h0, 32'hC0DE_0000 + c);
      issue("R7 vu rw", O_SET, 5'd4, M_VU, cfgOf(c[1], c[0]), 32'h0, 32'hCAFE_0000 + c);
    end
    checkIdle("R7");
  endtask

  task automatic testPopAndIgnore();
    issue("R8 grant", O_WR, 5'd9, M_M, cfgOf(0, 0), 32'h0, 32'h2468_ACE0);
    checkIdle("R8 pop drop");
    issue("R9 wdata a", O_WR, 5'd9, M_S, cfgOf(1, 0), 32'h0000_0000, 32'hFEED_0001);
    issue("R9 wdata b", O_WR, 5'd9, M_S, cfgOf(1, 0), 32'hFFFF_FFFF, 32'hFEED_0001);
    issue("R9 wdata refused", O_WR, 5'd9, M_U, cfgOf(1, 0), 32'hFFFF_FFFF, 32'hFEED_0002);
    checkIdle("R9");
  endtask

  task automatic testReserved();
    issue("R10 op rsvd", O_RSVD, 5'd5, M_M, cfgOf(1, 1), 32'h0, 32'h0F0F_0F0F);
    issue("R10 mode 010", O_WR, 5'd5, 3'b010, cfgOf(1, 1), 32'h0, 32'h0F0F_0F0F);
    issue("R10 mode 110", O_WR, 5'd5, 3'b110, cfgOf(1, 1), 32'h0, 32'h0F0F_0F0F);
    issue("R10 mode 111", O_WR, 5'd5, 3'b111, cfgOf(1, 1), 32'h0, 32'h0F0F_0F0F);
    checkIdle("R10 R11");
  endtask

  task automatic testBackToBack();
    // Consecutive requests: each response reflects its own request cycle (R2).
    issue("R2 b2b first", O_WR, 5'd1, M_M, cfgOf(0, 0), 32'h0, 32'h1000_0001);
    issue("R2 b2b second", O_WR, 5'd1, M_U, cfgOf(0, 0), 32'h0, 32'h1000_0002);
    issue("R2 b2b third", O_WR, 5'd1, M_M, cfgOf(0, 0), 32'h0, 32'h1000_0003);
    checkIdle("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadOnly();
    testMachine();
    testUser();
    testSuper();
    testVirtual();
    testPopAndIgnore();
    testReserved();
    testBackToBack();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule